// File: doc/BRIEF.md
# Unmapped Access Bus Error Generator

This block watches the address bus of a secondary processor and decides on every access whether the address lands in one of the decoded windows. There are three windows: a base DRAM bank, an optional DRAM extension and a small shared mailbox. An access that hits none of them is a fault.

On a fault the block raises a bus-error line to the processor. It records the faulting address, the transfer direction and the processor function code. It keeps the error line high for a fixed number of clocks so that an interrupted read-modify-write sequence can finish. During that window it ignores any further faults.

A read of an unmapped location is answered with an all-ones fill word. Side-effect-free debug accesses get the same fill word but never raise an error.

Top module: `ufault_buserr`

## Requirements
- R1: The mapped windows are 0x0000_0000–0x003F_FFFF, 0x0040_0000–0x00FF_FFFF (present when `OPT_DRAM_EN` is 1, the default) and 0xFFFF_8000–0xFFFF_9FFF. An access inside them never raises `bus_err` and leaves the captured fault record unchanged.
- R2: An access with `acc_valid`=1 and `acc_debug`=0 to any other address, made while `bus_err` is low, drives `bus_err` high on the next clock.
- R3: Once raised, `bus_err` stays high for exactly `HOLD_CYCLES` clocks (16 by default) and then falls.
- R4: The captured `flt_addr` is the access address with bits 1:0 cleared. One is added to it when `acc_be[3:2]` (the lanes for data bits 31:16) are both zero.
- R5: `flt_write` and `flt_fc` capture `acc_write` and `acc_fc` of the faulting access, on the same clock as `flt_addr`.
- R6: While `bus_err` is high, further unmapped accesses neither restart the hold window nor change `flt_addr`, `flt_write` or `flt_fc`.
- R7: Every valid read of an unmapped address gives `fill_en`=1 and `fill_data`=0xFFFF_FFFF on the next clock. Otherwise both are zero on that clock.
- R8: An unmapped access with `acc_debug`=1 gets the fill response of R7 but does not raise `bus_err` or change the fault record.
- R9: Synchronous reset clears `bus_err`, `fill_en`, `fill_data` and the fault record to zero.
- R10: An unmapped access issued on the first clock after `bus_err` falls is accepted as a new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_debug | input | 1 | Side-effect-free access; never faults |
| acc_addr | input | 32 | Byte address of the access |
| acc_be | input | DATA_W/8 | Byte lane enables; bit 3 is data bits 31:24 |
| acc_fc | input | FC_W | Processor function code |
| bus_err | output | 1 | Bus-error request to the processor |
| flt_addr | output | 32 | Captured (adjusted) fault address |
| flt_write | output | 1 | Captured direction of the fault |
| flt_fc | output | FC_W | Captured function code of the fault |
| fill_en | output | 1 | Fill word is valid for an unmapped read |
| fill_data | output | DATA_W | Read data for an unmapped read |

## Verification
The bound checker enforces several rules on every cycle. An idle unmapped access must fault on the next clock and carry the right direction and function code. The error window must last exactly the hold count. The fault record must stay frozen while the error is active. Mapped and debug accesses must never fault, and the fill response must follow the decode. The bench covers what the checker does not. It sweeps boundary and pseudo-random addresses through all lane-enable patterns and checks the address adjustment arithmetically. It also shows that a second fault injected in mid-window is dropped, and that a fault issued on the first clock after release is taken.

// File: rtl/ufault_pkg.sv
package ufault_pkg;
  localparam int ADDR_W      = 32;
  localparam int NUM_REGIONS = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  // window bounds, inclusive; index 1 is the optional DRAM extension
  localparam addr_t REGION_LO [NUM_REGIONS] = '{32'h0000_0000, 32'h0040_0000, 32'hFFFF_8000};
  localparam addr_t REGION_HI [NUM_REGIONS] = '{32'h003F_FFFF, 32'h00FF_FFFF, 32'hFFFF_9FFF};
  localparam int    OPT_REGION = 1;
endpackage

// File: rtl/ufault_decode.sv
module ufault_decode
  import ufault_pkg::*;
#(
  parameter bit OPT_DRAM_EN = 1'b1
) (
  input  addr_t addr,
  output logic  miss
);
  logic [NUM_REGIONS-1:0] hit_vec;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam addr_t SPAN = REGION_HI[r] - REGION_LO[r];
    if (r == OPT_REGION && !OPT_DRAM_EN) begin : g_off
      assign hit_vec[r] = 1'b0;
    end else begin : g_on
      addr_t offs;
      assign offs       = addr - REGION_LO[r];
      assign hit_vec[r] = (offs <= SPAN);
    end
  end

  assign miss = ~|hit_vec;
endmodule

// File: rtl/ufault_hold.sv
module ufault_hold #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (fire) begin
      busy  <= 1'b1;
      cnt_q <= LOAD_V;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ufault_capture.sv
module ufault_capture
  import ufault_pkg::*;
#(
  parameter int BE_W = 4,
  parameter int FC_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  addr_t           addr,
  input  logic [BE_W-1:0] be,
  input  logic            write,
  input  logic [FC_W-1:0] fc,
  output addr_t           flt_addr,
  output logic            flt_write,
  output logic [FC_W-1:0] flt_fc
);
  localparam int LANE_BITS = (BE_W > 1) ? $clog2(BE_W) : 1;
  localparam int HALF      = BE_W / 2;

  addr_t aligned;
  logic  low_only;

  assign aligned  = {addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
  assign low_only = ~|be[BE_W-1:HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_addr  <= '0;
      flt_write <= 1'b0;
      flt_fc    <= '0;
    end else if (load) begin
      flt_addr  <= aligned + ADDR_W'(low_only);
      flt_write <= write;
      flt_fc    <= fc;
    end
  end
endmodule

// File: rtl/ufault_buserr.sv
module ufault_buserr
  import ufault_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int DATA_W      = 32,
  parameter int FC_W        = 3,
  parameter bit OPT_DRAM_EN = 1'b1,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_debug,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BE_W-1:0]   acc_be,
  input  logic [FC_W-1:0]   acc_fc,
  output logic              bus_err,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_write,
  output logic [FC_W-1:0]   flt_fc,
  output logic              fill_en,
  output logic [DATA_W-1:0] fill_data
);
  logic addr_miss;
  logic fire;

  ufault_decode #(.OPT_DRAM_EN(OPT_DRAM_EN)) decode_i (
    .addr (acc_addr),
    .miss (addr_miss)
  );

  assign fire = acc_valid & addr_miss & ~acc_debug & ~bus_err;

  ufault_hold #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .busy (bus_err)
  );

  ufault_capture #(.BE_W(BE_W), .FC_W(FC_W)) cap_i (
    .clk       (clk),
    .rst       (rst),
    .load      (fire),
    .addr      (acc_addr),
    .be        (acc_be),
    .write     (acc_write),
    .fc        (acc_fc),
    .flt_addr  (flt_addr),
    .flt_write (flt_write),
    .flt_fc    (flt_fc)
  );

  // fill response for unmapped reads, debug or not
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_en   <= 1'b0;
      fill_data <= '0;
    end else begin
      fill_en   <= acc_valid & addr_miss & ~acc_write;
      fill_data <= (acc_valid & addr_miss & ~acc_write) ? '1 : '0;
    end
  end
endmodule

// File: rtl/ufault_buserr_chk.sv
module ufault_buserr_chk #(
  parameter int HOLD_CYCLES = 16,
  parameter int DATA_W      = 32,
  parameter int FC_W        = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_debug,
  input logic              addr_miss,
  input logic [FC_W-1:0]   acc_fc,
  input logic              bus_err,
  input logic [31:0]       flt_addr,
  input logic              flt_write,
  input logic [FC_W-1:0]   flt_fc,
  input logic              fill_en,
  input logic [DATA_W-1:0] fill_data
);
  localparam int HW = $clog2(HOLD_CYCLES + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (bus_err) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R1: mapped accesses never fault
  p_mapped_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !addr_miss && !bus_err) |=> !bus_err);

  // R2 and R5: idle fault raises the error and records direction and code
  p_fault_raise_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && addr_miss && !acc_debug && !bus_err) |=>
      (bus_err && flt_write == $past(acc_write) && flt_fc == $past(acc_fc)));

  p_hold_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_err) |-> (hi_cnt == HW'(HOLD_CYCLES)));

  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> ($stable(flt_addr) && $stable(flt_write) && $stable(flt_fc)));

  p_fill_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && addr_miss && !acc_write) |=> (fill_en && fill_data == '1));

  p_no_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || !addr_miss || acc_write) |=> (!fill_en && fill_data == '0));

  p_debug_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_debug && !bus_err) |=> !bus_err);
endmodule

bind ufault_buserr ufault_buserr_chk #(
  .HOLD_CYCLES(HOLD_CYCLES), .DATA_W(DATA_W), .FC_W(FC_W)
) chk_i (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_debug(acc_debug), .addr_miss(addr_miss), .acc_fc(acc_fc),
  .bus_err(bus_err), .flt_addr(flt_addr), .flt_write(flt_write),
  .flt_fc(flt_fc), .fill_en(fill_en), .fill_data(fill_data)
);

// File: tb/ufault_buserr_tb_top.sv
module ufault_buserr_tb_top;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_debug = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [2:0]  acc_fc = '0;
  logic        bus_err, flt_write, fill_en;
  logic [31:0] flt_addr, fill_data;
  logic [2:0]  flt_fc;

  int checks = 0, errors = 0;
  logic [31:0] exp_faddr = '0;
  logic        exp_fwr = 1'b0;
  logic [2:0]  exp_ffc = '0;

  always #5 clk = ~clk;

  ufault_buserr dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_debug(acc_debug), .acc_addr(acc_addr), .acc_be(acc_be), .acc_fc(acc_fc),
    .bus_err(bus_err), .flt_addr(flt_addr), .flt_write(flt_write), .flt_fc(flt_fc),
    .fill_en(fill_en), .fill_data(fill_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [31:0] a);
    return (a < 32'h0100_0000) || (a >= 32'hFFFF_8000 && a <= 32'hFFFF_9FFF);
  endfunction

  task automatic drive(input logic [31:0] a, input bit wr, input logic [3:0] be,
                       input logic [2:0] fc, input bit dbg);
    @(negedge clk);
    acc_addr = a; acc_write = wr; acc_be = be; acc_fc = fc; acc_debug = dbg;
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; acc_debug = 1'b0;
  endtask

  // counts remaining high cycles; the caller has already seen one
  task automatic measure_hold(input string req);
    int n = 1;
    while (bus_err && n < 40) begin
      @(negedge clk);
      if (bus_err) n++;
    end
    chk(req, n, HOLD);
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input logic [3:0] be,
                        input logic [2:0] fc, input bit dbg);
    bit miss = !is_mapped(a);
    bit err  = miss && !dbg;
    drive(a, wr, be, fc, dbg);
    chk(dbg ? "R8 bus_err" : (miss ? "R2 bus_err" : "R1 bus_err"), bus_err, err);
    chk("R7 fill_en", fill_en, miss && !wr);
    chk("R7 fill_data", fill_data, (miss && !wr) ? 32'hFFFF_FFFF : 32'h0);
    if (err) begin
      exp_faddr = {a[31:2], 2'b00} + ((be[3:2] == 2'b00) ? 32'd1 : 32'd0);
      exp_fwr = wr; exp_ffc = fc;
    end
    chk("R4 flt_addr", flt_addr, exp_faddr);
    chk("R5 flt_write", flt_write, exp_fwr);
    chk("R5 flt_fc", flt_fc, exp_ffc);
    if (err) measure_hold("R3 hold length");
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    logic [3:0]  be_pat [4] = '{4'hF, 4'hC, 4'h3, 4'h1};
    logic [31:0] edges [10] = '{32'h0, 32'h003F_FFFC, 32'h0040_0000, 32'h00FF_FFFC,
                                32'h0100_0000, 32'hFFFF_7FFC, 32'hFFFF_8000,
                                32'hFFFF_9FFC, 32'hFFFF_A000, 32'hFFFF_FFFC};
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 bus_err", bus_err, 0);
    chk("R9 flt_addr", flt_addr, 0);
    chk("R9 fill_en", fill_en, 0);
    chk("R9 fill_data", fill_data, 0);
    rst = 1'b0;

    // R1 boundary sweep with every lane pattern
    for (int i = 0; i < 10; i++)
      for (int b = 0; b < 4; b++)
        access(edges[i] + 32'(b), (b % 2) == 1, be_pat[b], 3'(i + b), 1'b0);

    // pseudo-random addresses, mixed windows
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (i % 4)
        1:       a = lcg & 32'h00FF_FFFF;
        2:       a = 32'hFFFF_0000 | (lcg & 32'h0000_FFFF);
        default: a = lcg;
      endcase
      access(a, lcg[3], be_pat[i % 4], lcg[6:4], lcg[9:8] == 2'b11);
    end

    // R8: debug reads/writes of unmapped space
    access(32'h8000_0000, 1'b0, 4'hF, 3'd5, 1'b1);
    access(32'h0200_0010, 1'b1, 4'h3, 3'd2, 1'b1);

    // R6: second fault in mid-window is dropped
    begin
      int n = 1;
      drive(32'h2000_0004, 1'b1, 4'hF, 3'd1, 1'b0);
      chk("R2 bus_err", bus_err, 1);
      chk("R4 flt_addr", flt_addr, 32'h2000_0004);
      @(negedge clk); n++;
      acc_addr = 32'h3000_0000; acc_write = 1'b0; acc_be = 4'h1;
      acc_fc = 3'd6; acc_valid = 1'b1;
      @(negedge clk); n++;
      acc_valid = 1'b0;
      chk("R6 flt_addr", flt_addr, 32'h2000_0004);
      chk("R6 flt_write", flt_write, 1);
      chk("R6 flt_fc", flt_fc, 1);
      chk("R7 fill in window", fill_en, 1);
      while (bus_err && n < 40) begin
        @(negedge clk);
        if (bus_err) n++;
      end
      chk("R6 hold not restarted", n, HOLD);
      // R10: first clock after release
      acc_addr = 32'h4000_0002; acc_write = 1'b0; acc_be = 4'h3;
      acc_fc = 3'd7; acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R10 bus_err", bus_err, 1);
      chk("R10 flt_addr", flt_addr, 32'h4000_0001);
      chk("R10 flt_fc", flt_fc, 7);
      exp_faddr = 32'h4000_0001; exp_fwr = 1'b0; exp_ffc = 3'd7;
      measure_hold("R3 hold after R10");
    end

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule